// File: doc/BRIEF.md
# Prescaled Free-Running Interval Timer

This block is an 8-bit up-counter that never stops. Its count rate comes from one tap of a free-running prescaler. The prescaler advances on clock-enable pulses from either a main or a sub clock source. The counter sets a sticky interrupt flag each time it wraps from its top value back to zero. The flag stays set until an acknowledge input clears it.

Software reaches the block through one register address. A read there returns the live count. A write there loads a control byte. The low three bits of that byte choose the prescale ratio, and bit 3 asks for a one-time clear of the counter and the prescaler. The design uses no derived clocks. Every register runs on the system clock, and the selected prescaler tap produces a one-cycle count-enable strobe.

Top module: `ivt_top`

## Requirements
- R1: After reset the count reads 0x00, the interrupt flag is 0 and the rate select is 7.
- R2: With rate select S (control byte bits [2:0]), the count rises by exactly one for every 2^(3+S) clock cycles in which the chosen source tick is high.
- R3: After reset, before any control write, the count first reaches 1 after 1024 source ticks and not after 1023.
- R4: A write to address 0xF4 with control byte bit 3 set makes the count read 0x00 from the second clock edge after the write. Counting then resumes with no further write.
- R5: The same clear also restarts the prescaler. The first increment after a clear therefore needs a full 2^(3+S) source ticks.
- R6: A read at address 0xF4 returns the count. A read at any other address returns 0x00. A write to any other address changes neither the count nor the rate select.
- R7: The interrupt flag rises on the increment that takes the count from 0xFF to 0x00. It holds through later increments until irq_ack is high at a clock edge.
- R8: When irq_ack and a wrap fall on the same clock edge, the flag is set.
- R9: While clk_mode[1] is 0 (modes 00 and 01), the counter follows main_tick and ignores sub_tick. While clk_mode[1] is 1 (modes 10 and 11), it follows sub_tick and ignores main_tick.
- R10: No control byte stops the counter. A write with bit 3 clear leaves the count unchanged, and counting goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| main_tick | input | 1 | Clock-enable pulse from the main source |
| sub_tick | input | 1 | Clock-enable pulse from the sub source |
| clk_mode | input | 2 | Clock-mode field; bit 1 selects the sub source |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data (control byte) |
| bus_rdata | output | 8 | Read data (count at 0xF4, else zero) |
| irq_ack | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Sticky wrap interrupt flag |

## Verification
The hardest case to reach is a wrap that lands on the same edge as an acknowledge. The stimulus gets there by clearing the timer at the fastest rate and then feeding exactly 2047 source ticks, which leaves the count at 0xFF one tick short of wrapping. It then drives the final tick in the same cycle as irq_ack. The prescaler restart is checked in a similar way. A clear is issued in the middle of a prescale period, and the bench then shows that seven further ticks give no increment.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   parameter int IVT_CNT_W     = 8;
   parameter int IVT_SEL_W     = 3;
   parameter int IVT_MIN_SHIFT = 3;
   parameter int IVT_ADDR_W    = 8;
   parameter int IVT_DATA_W    = 8;
   parameter int IVT_CLR_BIT   = 3;
   parameter logic [IVT_ADDR_W-1:0] IVT_ADDR = 8'hF4;
endpackage

// File: rtl/ivt_ctrl.sv
module ivt_ctrl #(
   parameter int ADDR_W  = ivt_pkg::IVT_ADDR_W,
   parameter int DATA_W  = ivt_pkg::IVT_DATA_W,
   parameter int SEL_W   = ivt_pkg::IVT_SEL_W,
   parameter int CLR_BIT = ivt_pkg::IVT_CLR_BIT,
   parameter logic [ADDR_W-1:0] TIMER_ADDR = ivt_pkg::IVT_ADDR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [SEL_W-1:0]  sel_o,
   output logic              clr_o
);
   logic hit;
   logic unused_wdata;

   if (CLR_BIT < SEL_W || CLR_BIT >= DATA_W) begin : g_bad_clr
      $error("ivt_ctrl: clear bit must sit above the select field and inside the data word");
   end

   assign hit          = bus_wr && (bus_addr == TIMER_ADDR);
   assign unused_wdata = ^bus_wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o <= '1;
         clr_o <= 1'b0;
      end else begin
         clr_o <= hit && bus_wdata[CLR_BIT];
         if (hit) sel_o <= bus_wdata[SEL_W-1:0];
      end
   end

   // R6
   foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr != TIMER_ADDR) |=> $stable(sel_o));

   // R4
   clear_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && bus_wdata[CLR_BIT]) |=> clr_o);
endmodule

// File: rtl/ivt_prescaler.sv
module ivt_prescaler #(
   parameter int SEL_W     = ivt_pkg::IVT_SEL_W,
   parameter int MIN_SHIFT = ivt_pkg::IVT_MIN_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_en,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             strobe
);
   localparam int NSEL  = 2 ** SEL_W;
   localparam int PRE_W = MIN_SHIFT + NSEL - 1;

   logic [PRE_W-1:0] pre;
   logic [NSEL-1:0]  tap_hit;

   if (MIN_SHIFT < 1) begin : g_bad_shift
      $error("ivt_prescaler: MIN_SHIFT must be at least 1");
   end
   if (SEL_W < 1 || SEL_W > 4) begin : g_bad_sel
      $error("ivt_prescaler: SEL_W must be 1 to 4");
   end

   for (genvar i = 0; i < NSEL; i++) begin : g_tap
      assign tap_hit[i] = &pre[MIN_SHIFT+i-1:0];
   end

   assign strobe = src_en && !clr && tap_hit[sel];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      pre <= '0;
      else if (clr)    pre <= '0;
      else if (src_en) pre <= pre + 1'b1;
   end

   // R5
   pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (pre == '0));

   // R2
   pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!src_en && !clr) |=> $stable(pre));
endmodule

// File: rtl/ivt_counter.sv
module ivt_counter #(
   parameter int CNT_W = ivt_pkg::IVT_CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             strobe,
   input  logic             clr,
   input  logic             ack,
   output logic [CNT_W-1:0] cnt,
   output logic             irq
);
   logic wrap;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("ivt_counter: CNT_W must be at least 2");
   end

   assign wrap = strobe && (cnt == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (clr)    cnt <= '0;
      else if (strobe) cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    irq <= 1'b0;
      else if (wrap) irq <= 1'b1;
      else if (ack)  irq <= 1'b0;
   end

   // R2
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe && !clr) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R10
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!strobe && !clr) |=> $stable(cnt));

   // R4
   count_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

   // R8
   wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> irq);

   // R7
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack) |=> irq);

   // R7
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !wrap) |=> !irq);
endmodule

// File: rtl/ivt_top.sv
module ivt_top #(
   parameter int CNT_W     = ivt_pkg::IVT_CNT_W,
   parameter int SEL_W     = ivt_pkg::IVT_SEL_W,
   parameter int MIN_SHIFT = ivt_pkg::IVT_MIN_SHIFT,
   parameter int ADDR_W    = ivt_pkg::IVT_ADDR_W,
   parameter int DATA_W    = ivt_pkg::IVT_DATA_W,
   parameter int CLR_BIT   = ivt_pkg::IVT_CLR_BIT,
   parameter logic [ADDR_W-1:0] TIMER_ADDR = ivt_pkg::IVT_ADDR
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              main_tick,
   input  logic              sub_tick,
   input  logic [1:0]        clk_mode,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              irq_ack,
   output logic              irq_flag
);
   logic             src_en;
   logic [SEL_W-1:0] sel;
   logic             clr;
   logic             strobe;
   logic [CNT_W-1:0] cnt;
   logic             unused_mode;

   if (CNT_W > DATA_W) begin : g_bad_width
      $error("ivt_top: count must fit the read data word");
   end

   assign unused_mode = clk_mode[0];
   assign src_en      = clk_mode[1] ? sub_tick : main_tick;

   ivt_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
      .CLR_BIT(CLR_BIT), .TIMER_ADDR(TIMER_ADDR)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .sel_o(sel), .clr_o(clr)
   );

   ivt_prescaler #(.SEL_W(SEL_W), .MIN_SHIFT(MIN_SHIFT)) u_pre (
      .clk(clk), .rst_n(rst_n), .src_en(src_en), .clr(clr),
      .sel(sel), .strobe(strobe)
   );

   ivt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .strobe(strobe), .clr(clr),
      .ack(irq_ack), .cnt(cnt), .irq(irq_flag)
   );

   assign bus_rdata = (bus_addr == TIMER_ADDR) ? DATA_W'(cnt) : '0;

   // R6
   read_mux_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != TIMER_ADDR) |-> (bus_rdata == '0));
endmodule

// File: tb/sim_ivt_top.sv
module sim_ivt_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       main_tick = 1'b0;
   logic       sub_tick = 1'b0;
   logic [1:0] clk_mode = 2'b00;
   logic [7:0] bus_addr = 8'hF4;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       irq_ack = 1'b0;
   logic       irq_flag;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   ivt_top u0 (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .sub_tick(sub_tick),
      .clk_mode(clk_mode), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_ack(irq_ack),
      .irq_flag(irq_flag)
   );

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic ticks(input bit use_sub, input int n);
      if (n > 0) begin
         @(negedge clk);
         if (use_sub) sub_tick = 1'b1; else main_tick = 1'b1;
         repeat (n) @(negedge clk);
         main_tick = 1'b0;
         sub_tick  = 1'b0;
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 8'hF4;
      @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 count", bus_rdata, 8'h00);
      chk("R1 irq", irq_flag, 0);
   endtask

   task automatic t_reset_rate;
      ticks(0, 1023);
      chk("R3 before 1024", bus_rdata, 0);
      ticks(0, 1);
      chk("R3 at 1024", bus_rdata, 1);
   endtask

   task automatic t_rates;
      wr(8'hF4, 8'h08);
      chk("R4 cleared", bus_rdata, 0);
      ticks(0, 7);
      chk("R2 sel0 7 ticks", bus_rdata, 0);
      ticks(0, 1);
      chk("R2 sel0 8 ticks", bus_rdata, 1);
      ticks(0, 72);
      chk("R2 sel0 80 ticks", bus_rdata, 10);
      wr(8'hF4, 8'h0D);
      ticks(0, 255);
      chk("R2 sel5 255 ticks", bus_rdata, 0);
      ticks(0, 513);
      chk("R2 sel5 768 ticks", bus_rdata, 3);
   endtask

   task automatic t_clear;
      wr(8'hF4, 8'h08);
      ticks(0, 165);
      chk("R2 sel0 165 ticks", bus_rdata, 20);
      wr(8'hF4, 8'h08);
      chk("R4 clear mid count", bus_rdata, 0);
      ticks(0, 7);
      chk("R5 prescaler restarted", bus_rdata, 0);
      ticks(0, 1);
      chk("R4 counting resumes", bus_rdata, 1);
   endtask

   task automatic t_wrap;
      wr(8'hF4, 8'h08);
      ticks(0, 8 * 255);
      chk("R7 at FF", bus_rdata, 8'hFF);
      chk("R7 no irq yet", irq_flag, 0);
      ticks(0, 8);
      chk("R7 wrapped", bus_rdata, 0);
      chk("R7 irq set", irq_flag, 1);
      ticks(0, 8);
      chk("R7 irq sticky", irq_flag, 1);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      chk("R7 ack clears", irq_flag, 0);
   endtask

   task automatic t_ack_race;
      wr(8'hF4, 8'h08);
      ticks(0, 2047);
      chk("R8 at FF", bus_rdata, 8'hFF);
      chk("R8 irq low", irq_flag, 0);
      @(negedge clk); main_tick = 1'b1; irq_ack = 1'b1;
      @(negedge clk); main_tick = 1'b0; irq_ack = 1'b0;
      chk("R8 overflow wins", irq_flag, 1);
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic t_source;
      clk_mode = 2'b10;
      wr(8'hF4, 8'h08);
      ticks(0, 16);
      chk("R9 main ignored in 10", bus_rdata, 0);
      ticks(1, 16);
      chk("R9 sub in 10", bus_rdata, 2);
      clk_mode = 2'b01;
      ticks(1, 16);
      chk("R9 sub ignored in 01", bus_rdata, 2);
      ticks(0, 8);
      chk("R9 main in 01", bus_rdata, 3);
      clk_mode = 2'b11;
      ticks(1, 8);
      chk("R9 sub in 11", bus_rdata, 4);
      clk_mode = 2'b00;
   endtask

   task automatic t_bus;
      wr(8'hF4, 8'h08);
      ticks(0, 40);
      chk("R2 five counts", bus_rdata, 5);
      wr(8'hF5, 8'h0F);
      chk("R6 foreign write no clear", bus_rdata, 5);
      @(negedge clk); bus_addr = 8'h12;
      #1 chk("R6 foreign read zero", bus_rdata, 0);
      bus_addr = 8'hF4;
      ticks(0, 8);
      chk("R6 rate unchanged", bus_rdata, 6);
      wr(8'hF4, 8'hF0);
      chk("R10 write keeps count", bus_rdata, 6);
      ticks(0, 8);
      chk("R10 still counting", bus_rdata, 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_reset_rate;
      t_rates;
      t_clear;
      t_wrap;
      t_ack_race;
      t_source;
      t_bus;
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule